// File: doc/BRIEF.md
# Fractional CPU Clock-Enable Controller

This block runs on a PLL-rate clock and produces a single-cycle clock-enable stream for the processor domain. Over any window of D consecutive cycles it asserts exactly N enables, where D is the active divider and N the active fraction, so the processor advances at N/D of the PLL rate. The enable pattern comes from an accumulator that adds N each cycle and takes D away whenever the running sum reaches D, which spreads the pulses evenly.

On top of the plain divider there are two speed-management features. When sleep is permitted and the processor signals that it is idle, the fraction drops to 1. When the processor wakes, the fraction either snaps back to the programmed value or, with the staircase option on, climbs in fixed increments. Each increment takes a programmable number of microseconds, and the climb stops exactly at the programmed value. Three registered status outputs report the divider, fraction and bus-ratio code currently in force. The actual clock muxing and the bus-ratio divider live elsewhere.

Top module: `frac_clk_ctrl`

## Requirements
- R1: After reset `cur_fdiv` is 10, `cur_ffrac` is 1, `cur_ratio` is 4 and `cpu_ce` is 0.
- R2: Once the active settings have held steady for three cycles, any `cur_fdiv` consecutive cycles contain exactly `cur_ffrac` cycles with `cpu_ce` high. A fraction of 0 gives no enables.
- R3: A programmed fraction above the divider is clamped to the divider, which gives a continuous enable. A divider code of 0 is treated as 1.
- R4: While sleep is not in force and no staircase is running, `cur_fdiv` and `cur_ffrac` take the clamped programmed values on the clock edge after the inputs change.
- R5: When `sleep_en` and `cpu_sleep` are both high, `cur_ffrac` becomes 1 on the next edge. `cpu_sleep` alone, with `sleep_en` low, leaves `cur_ffrac` unchanged.
- R6: With `step_en` low while sleeping, `cur_ffrac` returns to the programmed fraction on the first edge after sleep ends.
- R7: With `step_en` high while sleeping, take k as the number of edges since sleep ended. Then `cur_ffrac` = min(1 + `step_size`·floor(k / (US_CYCLES·L)), programmed fraction), where L is `step_len`, or 1 when `step_len` is 0.
- R8: The staircase never exceeds the programmed fraction. Once it reaches that value, it tracks the programmed value directly.
- R9: `cur_ratio` takes a new `cfg_ratio` on the next edge only for codes 2 (1:2), 4 (1:3), 6 (1:4), 7 (1:5) and 8 (1:10). Any other code is ignored and the previous ratio is kept.
- R10: A `step_size` of 0 ends the staircase, and the programmed fraction is restored on the first edge after wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fdiv | input | 5 | Programmed divider (1..31, 0 read as 1) |
| cfg_ffrac | input | 5 | Programmed fraction (0..31) |
| cfg_ratio | input | 4 | Requested bus-to-CPU ratio code |
| sleep_en | input | 1 | Permits sleep-mode slowdown |
| cpu_sleep | input | 1 | Processor idle indication |
| step_en | input | 1 | Selects staircase ramp on wake |
| step_size | input | 5 | Fraction increment per step |
| step_len | input | 8 | Step period in microseconds |
| cpu_ce | output | 1 | Processor clock enable |
| cur_fdiv | output | 5 | Divider in force |
| cur_ffrac | output | 5 | Fraction in force |
| cur_ratio | output | 4 | Ratio code in force |

## Verification
The bench counts enables over whole divider windows for ordinary, zero, equal and over-range fractions, and for a divider code of 0. An accumulator that compares against the wrong bound, or that skips the clamp, shows up there as one pulse too many or too few. It follows the wake staircase edge by edge around each step boundary. This catches a step timer that is off by one, increments that land a microsecond early, and a last step that overshoots instead of saturating. It also checks that sleep without permission has no effect, that wake without the staircase snaps back, that a zero step size does not leave the ramp stuck, and that reserved ratio codes leave the previous code in place.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
  localparam int FRAC_W  = 5;
  localparam int RATIO_W = 4;
  localparam logic [FRAC_W-1:0]  DIV_RST   = FRAC_W'(10);
  localparam logic [FRAC_W-1:0]  FRAC_RST  = FRAC_W'(1);
  localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(4);

  // divider code 0 is read as 1
  function automatic logic [FRAC_W-1:0] eff_div(input logic [FRAC_W-1:0] d);
    return (d == '0) ? FRAC_W'(1) : d;
  endfunction

  // fraction may not exceed the divider
  function automatic logic [FRAC_W-1:0] clamp_frac(input logic [FRAC_W-1:0] f,
                                                   input logic [FRAC_W-1:0] d);
    return (f > d) ? d : f;
  endfunction

  // one staircase increment, saturating at the target
  function automatic logic [FRAC_W-1:0] step_add(input logic [FRAC_W-1:0] cur,
                                                 input logic [FRAC_W-1:0] inc,
                                                 input logic [FRAC_W-1:0] tgt);
    logic [FRAC_W:0] s;
    s = {1'b0, cur} + {1'b0, inc};
    return (s >= {1'b0, tgt}) ? tgt : s[FRAC_W-1:0];
  endfunction

  function automatic logic ratio_ok(input logic [RATIO_W-1:0] r);
    case (r)
      RATIO_W'(2), RATIO_W'(4), RATIO_W'(6), RATIO_W'(7), RATIO_W'(8): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/frac_pulse_gen.sv
module frac_pulse_gen
  import frac_clk_pkg::*;
#(
  parameter int W = FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_div,
  input  logic [W-1:0] next_div,
  input  logic [W-1:0] frac,
  output logic         ce
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;
  logic [W:0]   acc_nxt;
  logic         hit;

  assign sum     = {1'b0, acc_q} + {1'b0, frac};
  assign hit     = (sum >= {1'b0, cur_div});
  assign acc_nxt = hit ? (sum - {1'b0, cur_div}) : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ce    <= 1'b0;
    end else begin
      ce    <= hit;
      acc_q <= (next_div != cur_div) ? '0 : acc_nxt[W-1:0];
    end
  end

  AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < cur_div); // R2
  AST_NO_CE_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (frac == '0 && acc_q < cur_div) |=> !ce); // R2
endmodule

// File: rtl/frac_ramp_ctrl.sv
module frac_ramp_ctrl
  import frac_clk_pkg::*;
#(
  parameter int W         = FRAC_W,
  parameter int CNT_W     = 8,
  parameter int US_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleeping,
  input  logic             step_en,
  input  logic [W-1:0]     step_size,
  input  logic [CNT_W-1:0] step_len,
  input  logic [W-1:0]     prog,
  output logic [W-1:0]     act_frac,
  output logic             ramp_busy,
  output logic             step_evt
);
  localparam int US_W = (US_CYCLES > 2) ? $clog2(US_CYCLES) : 1;
  localparam logic [US_W-1:0] US_LAST = US_W'(US_CYCLES - 1);

  logic [US_W-1:0]  us_q;
  logic [CNT_W-1:0] stp_q;
  logic [CNT_W-1:0] len1;
  logic             us_tick;
  logic             at_top;

  assign len1     = (step_len == '0) ? CNT_W'(1) : step_len;
  assign us_tick  = (us_q == US_LAST);
  assign at_top   = (act_frac >= prog);
  assign step_evt = ramp_busy & ~sleeping & ~at_top & (step_size != '0)
                    & us_tick & (stp_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_frac  <= FRAC_RST;
      ramp_busy <= 1'b0;
      us_q      <= '0;
      stp_q     <= CNT_W'(1);
    end else if (sleeping) begin
      act_frac  <= W'(1);
      ramp_busy <= step_en;
      us_q      <= '0;
      stp_q     <= len1;
    end else if (ramp_busy) begin
      if (at_top || step_size == '0) begin
        act_frac  <= prog;
        ramp_busy <= 1'b0;
        us_q      <= '0;
      end else begin
        us_q <= us_tick ? '0 : us_q + US_W'(1);
        if (us_tick)
          stp_q <= (stp_q <= CNT_W'(1)) ? len1 : stp_q - CNT_W'(1);
        if (step_evt) begin
          act_frac <= step_add(act_frac, step_size, prog);
          if (step_add(act_frac, step_size, prog) == prog) ramp_busy <= 1'b0;
        end
      end
    end else begin
      act_frac <= prog;
      us_q     <= '0;
    end
  end

  AST_SLEEP_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |=> act_frac == W'(1)); // R5
  AST_RAMP_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_busy && !sleeping) |=> act_frac <= $past(prog)); // R8
  AST_STEP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> act_frac > $past(act_frac)); // R7
  AST_NOSTEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && !ramp_busy) |=> act_frac == $past(prog)); // R6
endmodule

// File: rtl/frac_clk_ctrl.sv
module frac_clk_ctrl
  import frac_clk_pkg::*;
#(
  parameter int US_CYCLES = 50,
  parameter int CNT_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAC_W-1:0]  cfg_fdiv,
  input  logic [FRAC_W-1:0]  cfg_ffrac,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               sleep_en,
  input  logic               cpu_sleep,
  input  logic               step_en,
  input  logic [FRAC_W-1:0]  step_size,
  input  logic [CNT_W-1:0]   step_len,
  output logic               cpu_ce,
  output logic [FRAC_W-1:0]  cur_fdiv,
  output logic [FRAC_W-1:0]  cur_ffrac,
  output logic [RATIO_W-1:0] cur_ratio
);
  logic [FRAC_W-1:0] div_in;
  logic [FRAC_W-1:0] prog;
  logic              sleeping;
  logic              ramp_busy;
  logic              step_evt;

  assign div_in   = eff_div(cfg_fdiv);
  assign prog     = clamp_frac(cfg_ffrac, div_in);
  assign sleeping = sleep_en & cpu_sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_fdiv  <= DIV_RST;
      cur_ratio <= RATIO_RST;
    end else begin
      cur_fdiv <= div_in;
      if (ratio_ok(cfg_ratio)) cur_ratio <= cfg_ratio;
    end
  end

  frac_ramp_ctrl #(.W(FRAC_W), .CNT_W(CNT_W), .US_CYCLES(US_CYCLES)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleeping  (sleeping),
    .step_en   (step_en),
    .step_size (step_size),
    .step_len  (step_len),
    .prog      (prog),
    .act_frac  (cur_ffrac),
    .ramp_busy (ramp_busy),
    .step_evt  (step_evt)
  );

  frac_pulse_gen #(.W(FRAC_W)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_div  (cur_fdiv),
    .next_div (div_in),
    .frac     (cur_ffrac),
    .ce       (cpu_ce)
  );

  AST_FRAC_LE_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ffrac <= cur_fdiv); // R3
  AST_RATIO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ok(cur_ratio)); // R9
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_ok(cfg_ratio) |=> $stable(cur_ratio)); // R9
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cur_fdiv != '0); // R3
endmodule

// File: tb/frac_clk_ctrl_test.sv
module frac_clk_ctrl_test;
  localparam int US = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_fdiv = 5'd10, cfg_ffrac = 5'd1, step_size = 5'd6;
  logic [3:0] cfg_ratio = 4'd4;
  logic       sleep_en = 1'b0, cpu_sleep = 1'b0, step_en = 1'b0;
  logic [7:0] step_len = 8'd2;
  logic       cpu_ce;
  logic [4:0] cur_fdiv, cur_ffrac;
  logic [3:0] cur_ratio;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frac_clk_ctrl #(.US_CYCLES(US)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_fdiv(cfg_fdiv), .cfg_ffrac(cfg_ffrac),
    .cfg_ratio(cfg_ratio), .sleep_en(sleep_en), .cpu_sleep(cpu_sleep),
    .step_en(step_en), .step_size(step_size), .step_len(step_len),
    .cpu_ce(cpu_ce), .cur_fdiv(cur_fdiv), .cur_ffrac(cur_ffrac),
    .cur_ratio(cur_ratio)
  );

  // {fdiv, ffrac, expected divider, expected fraction}
  localparam logic [19:0] VEC [10] = '{
    {5'd10, 5'd1,  5'd10, 5'd1},  {5'd10, 5'd3,  5'd10, 5'd3},
    {5'd7,  5'd7,  5'd7,  5'd7},  {5'd31, 5'd0,  5'd31, 5'd0},
    {5'd5,  5'd9,  5'd5,  5'd5},  {5'd31, 5'd17, 5'd31, 5'd17},
    {5'd1,  5'd1,  5'd1,  5'd1},  {5'd0,  5'd0,  5'd1,  5'd0},
    {5'd0,  5'd4,  5'd1,  5'd1},  {5'd12, 5'd11, 5'd12, 5'd11}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int ramp_exp(input int k, input int inc, input int len, input int tgt);
    int v;
    v = 1 + inc * (k / (US * len));
    return (v > tgt) ? tgt : v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    check("R1 div",   cur_fdiv, 10);
    check("R1 frac",  cur_ffrac, 1);
    check("R1 ratio", cur_ratio, 4);
    check("R1 ce",    cpu_ce, 0);
    rst_n = 1'b1;

    // R2 R3 R4: vector walk
    for (int v = 0; v < 10; v++) begin
      int cnt;
      cfg_fdiv  = VEC[v][19:15];
      cfg_ffrac = VEC[v][14:10];
      edges(1);
      check("R4 div follows",  cur_fdiv,  VEC[v][9:5]);
      check("R3/R4 frac",      cur_ffrac, VEC[v][4:0]);
      edges(3);
      cnt = 0;
      for (int c = 0; c < 2 * VEC[v][9:5]; c++) begin
        edges(1);
        cnt += cpu_ce;
      end
      check("R2 enable count", cnt, 2 * VEC[v][4:0]);
    end

    // R5: sleep without permission is ignored
    cfg_fdiv = 5'd24; cfg_ffrac = 5'd20;
    edges(2);
    cpu_sleep = 1'b1;
    edges(3);
    check("R5 no permit", cur_ffrac, 20);
    sleep_en = 1'b1;
    edges(1);
    check("R5 sleep frac", cur_ffrac, 1);
    begin
      int cnt = 0;
      edges(3);
      for (int c = 0; c < 48; c++) begin edges(1); cnt += cpu_ce; end
      check("R5 sleep count", cnt, 2);
    end

    // R6: wake without staircase
    cpu_sleep = 1'b0;
    edges(1);
    check("R6 snap back", cur_ffrac, 20);

    // R7 R8: staircase, step 6, 2 us
    step_en = 1'b1; cpu_sleep = 1'b1;
    edges(4);
    cpu_sleep = 1'b0;
    for (int k = 1; k <= 450; k++) begin
      edges(1);
      if (k == 1 || k == 99 || k == 100 || k == 101 || k == 199 || k == 200 ||
          k == 300 || k == 399)
        check("R7 ramp", cur_ffrac, ramp_exp(k, 6, 2, 20));
      if (k == 400 || k == 450)
        check("R8 saturate", cur_ffrac, ramp_exp(k, 6, 2, 20));
    end
    cfg_ffrac = 5'd22;
    edges(1);
    check("R8 track", cur_ffrac, 22);

    // R7: step_len 0 behaves as 1 us, step 7
    step_len = 8'd0; step_size = 5'd7; cpu_sleep = 1'b1;
    edges(3);
    cpu_sleep = 1'b0;
    for (int k = 1; k <= 60; k++) begin
      edges(1);
      if (k == 49 || k == 50) check("R7 len0", cur_ffrac, ramp_exp(k, 7, 1, 22));
    end

    // R10: zero step size
    step_size = 5'd0; cpu_sleep = 1'b1;
    edges(3);
    cpu_sleep = 1'b0;
    edges(1);
    check("R10 zero step", cur_ffrac, 22);

    // R9: ratio codes
    cfg_ratio = 4'd8;  edges(1); check("R9 valid 8", cur_ratio, 8);
    cfg_ratio = 4'd3;  edges(2); check("R9 reserved 3", cur_ratio, 8);
    cfg_ratio = 4'd15; edges(2); check("R9 reserved 15", cur_ratio, 8);
    cfg_ratio = 4'd2;  edges(1); check("R9 valid 2", cur_ratio, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule